// File: doc/BRIEF.md
# Stoppable Divided Clock Output Generator

This block derives a slower clock from its fast input clock by counting input cycles against a programmable period. Once the counter reaches an active compare value the output moves to its active level, and when the counter wraps the output returns to the off level. For a 50% duty cycle, the compare value is set to about half the period. For example, a 36 MHz input with a period value of 5 and a compare value of 2 gives a 6 MHz output.

The compare value is never used directly. Software writes it into a holding register, and the block moves it into the active compare register only when the counter wraps. A compare value of zero parks the output at a programmable off level. Software can therefore stop the output by writing zero and restart it by writing the half-period value again. Neither action can produce a shortened pulse.

Software drives a small register write port that sets the period, the compare holding register, the off level and the run enable. The only other port is the registered clock output.

Top module: `stopclk_gen`

## Requirements
- R1: After reset the counter is zero, the compare holding and active registers are zero, the run enable is clear, the off level is 0 and `clk_out` is 0. Enabling the block without programming a compare value leaves `clk_out` at 0.
- R2: While running, the counter steps from 0 up to the period value and then wraps to 0, so one output period lasts (period value + 1) input cycles.
- R3: With a nonzero active compare value C and period value T, the cycle in which the counter equals C drives `clk_out` to the inverse of the off level in the following cycle. The wrap cycle drives it back to the off level. A wrap takes priority over a match. After the block is enabled, the active phase therefore starts in the third sampled cycle and lasts T−C cycles.
- R4: A compare write lands in the holding register. While running, the holding value moves into the active compare register only in a wrap cycle. While disabled, the move happens every cycle. An active phase that is already under way is never shortened by a compare write.
- R5: An active compare value of zero holds `clk_out` at the off level. Writing zero while the output is toggling ends it after a full active phase.
- R6: `clk_out` leaves the off level only on a compare match. After a restart, the first active phase has the full length T−C.
- R7: The off level is programmable. While the output is stopped, `clk_out` takes a new off level one cycle after the write lands.
- R8: While the run enable is clear, the counter is held at 0 and `clk_out` sits at the off level.
- R9: The write port applies `wr_data` when `wr_en` is high, selected by `wr_sel`: 0 = period value, 1 = compare holding register, 2 = off level (bit 0), 3 = run enable (bit 0). A write takes effect at the clock edge that samples it.
- R10: If the period value is lowered below the current count, the counter wraps in its next running cycle instead of running through its full range.
- R11: `clk_out` comes straight from a flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (see R9) |
| wr_data | input | CNT_W | Write data |
| clk_out | output | 1 | Divided clock output |

## Verification
A wrong counter or compare state shows up at `clk_out` within one output period. A stale active compare value alters the active-phase length. A counter that misses its wrap stretches the period or stops the edges. A compare value that transfers too early leaves a truncated active pulse that is visible when the run is measured. The bench therefore counts active cycles and edges over whole periods, checks run lengths across stop, restart and compare changes, and checks the exact cycle of the first match after enable. The checker flags a wrong off level or a premature compare load on the cycle after it happens.

// File: rtl/stopclk_pkg.sv
// Shared definitions for the stoppable clock generator.
// Assumes a two-bit register select on the write port.
package stopclk_pkg;
    typedef enum logic [1:0] {
        SEL_TOP = 2'd0,
        SEL_CMP = 2'd1,
        SEL_OFF = 2'd2,
        SEL_EN  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/stopclk_regs.sv
// Software-visible settings: period, compare holding value, off level, run enable.
// Assumes one write per cycle that takes effect at the sampling edge.
module stopclk_regs
    import stopclk_pkg::*;
#(
    parameter int   CNT_W   = 16,
    parameter int   TOP_RST = 5,
    parameter logic OFF_RST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] top_q,
    output logic [CNT_W-1:0] cmp_buf_q,
    output logic             off_q,
    output logic             run_q
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_sel);

    // Decode writes into the setting registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q     <= CNT_W'(TOP_RST);
            cmp_buf_q <= '0;
            off_q     <= OFF_RST;
            run_q     <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_TOP: top_q     <= wr_data;
                SEL_CMP: cmp_buf_q <= wr_data;
                SEL_OFF: off_q     <= wr_data[0];
                SEL_EN:  run_q     <= wr_data[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/stopclk_count.sv
// Period counter plus the active compare register, which loads from the
// holding register at the wrap (or continuously while idle).
// Assumes top_q may change at any time; a count at or above top wraps.
module stopclk_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] top,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_act_q,
    output logic             wrap,
    output logic             match
);
    assign wrap  = run && (cnt_q >= top);
    assign match = run && (cmp_act_q != '0) && (cnt_q == cmp_act_q);

    // Advance the counter while running; park it at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!run)  cnt_q <= '0;
        else if (wrap)  cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    // Move the holding compare into the active compare at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)              cmp_act_q <= '0;
        else if (!run || wrap)   cmp_act_q <= cmp_buf;
    end
endmodule

// File: rtl/stopclk_outstage.sv
// Registered output level: active on a compare match, off at the wrap,
// parked at the off level when idle or when the compare is zero.
// Assumes wrap and match come from the same cycle's count.
module stopclk_outstage (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic stopped,
    input  logic wrap,
    input  logic match,
    input  logic off_lvl,
    output logic out_q
);
    // Choose the next output level with wrap ahead of match.
    always_ff @(posedge clk) begin
        if (!rst_n)                out_q <= 1'b0;
        else if (!run || stopped)  out_q <= off_lvl;
        else if (wrap)             out_q <= off_lvl;
        else if (match)            out_q <= ~off_lvl;
    end
endmodule

// File: rtl/stopclk_gen.sv
// Top level of the stoppable divided clock output generator.
// Assumes the reset value of OFF_RST is 0, as the output stage resets low.
module stopclk_gen #(
    parameter int CNT_W   = 16,
    parameter int TOP_RST = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             clk_out
);
    logic [CNT_W-1:0] top_q, cmp_buf_q, cnt_q, cmp_act_q;
    logic             off_q, run_q, wrap, match, stopped;

    stopclk_regs #(.CNT_W(CNT_W), .TOP_RST(TOP_RST), .OFF_RST(1'b0)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .top_q(top_q), .cmp_buf_q(cmp_buf_q),
        .off_q(off_q), .run_q(run_q)
    );

    stopclk_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run(run_q), .top(top_q),
        .cmp_buf(cmp_buf_q), .cnt_q(cnt_q), .cmp_act_q(cmp_act_q),
        .wrap(wrap), .match(match)
    );

    assign stopped = (cmp_act_q == '0);

    stopclk_outstage u_out (
        .clk(clk), .rst_n(rst_n), .run(run_q), .stopped(stopped),
        .wrap(wrap), .match(match), .off_lvl(off_q), .out_q(clk_out)
    );
endmodule

// File: rtl/stopclk_chk.sv
// Property checker for stopclk_gen, attached with bind.
module stopclk_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             wrap,
    input logic             match,
    input logic             off_lvl,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_act,
    input logic             clk_out
);
    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (clk_out == $past(off_lvl))); // R8
    AST_STOPPED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_act == '0) |=> (clk_out == $past(off_lvl))); // R5
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap) |=> (cnt == '0)); // R2
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(cmp_act)); // R4
    AST_LEAVE_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out == off_lvl && !match) |=> (clk_out == $past(off_lvl))); // R6
    AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R8
endmodule

bind stopclk_gen stopclk_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_q), .wrap(wrap), .match(match),
    .off_lvl(off_q), .cnt(cnt_q), .cmp_act(cmp_act_q), .clk_out(clk_out)
);

// File: tb/stopclk_gen_bench.sv
module stopclk_gen_bench;
    localparam int W = 16;
    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic clk_out;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    stopclk_gen #(.CNT_W(W)) u_stopclk_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .clk_out(clk_out)
    );

    always #10 clk = ~clk;

    // {top, compare, off level}
    localparam int VEC [0:5][0:2] = '{
        '{5, 2, 0}, '{5, 2, 1}, '{9, 4, 0}, '{3, 1, 1}, '{7, 3, 0}, '{4, 0, 1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count active cycles and off-to-active edges over n samples.
    task automatic measure(input int n, input logic off, output int act, output int edges);
        logic prev = clk_out;
        act = 0; edges = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_out != off) act++;
            if (prev == off && clk_out != off) edges++;
            prev = clk_out;
        end
    endtask

    // Every complete active run must be len_a or len_b long.
    task automatic runs(input int n, input logic off, input int len_a, input int len_b,
                        output int bad, output int seen);
        bit started = 0;
        int len = 0;
        bad = 0; seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_out == off) begin
                if (started && len > 0) begin
                    seen++;
                    if (len != len_a && len != len_b) bad++;
                end
                started = 1; len = 0;
            end else if (started) len++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int act, edges, bad, seen;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check(clk_out == 1'b0, "R1 reset level", clk_out, 0);
        wr(3, 1);
        measure(20, 1'b0, act, edges);
        check(act == 0, "R1 unprogrammed compare stays quiet", act, 0);
        wr(3, 0);

        // Table walk: period and duty per vector (R2, R9, R11)
        for (int v = 0; v < 6; v++) begin
            int t = VEC[v][0], c = VEC[v][1];
            logic o = 1'(VEC[v][2]);
            wr(3, 0); wr(0, t); wr(1, c); wr(2, o); wr(3, 1);
            idle(3 * (t + 1) + 4);
            measure(4 * (t + 1), o, act, edges);
            check(act == ((c == 0) ? 0 : 4 * (t - c)), "R2 active cycles", act,
                  (c == 0) ? 0 : 4 * (t - c));
            check(edges == ((c == 0) ? 0 : 4), "R9 edges per window", edges, (c == 0) ? 0 : 4);
        end

        // R3: exact phase of first match after enabling, T=5 C=2 off=0
        wr(3, 0); wr(0, 5); wr(1, 2); wr(2, 0);
        wr(3, 1);
        begin
            int pat = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                pat = (pat << 1) | int'(clk_out);
            end
            check(pat == 6'b001110, "R3 match/wrap phase", pat, 6'b001110);
        end

        // R5: stop by writing zero, off level 1
        wr(3, 0); wr(2, 1); wr(1, 2); wr(3, 1);
        idle(15);
        wr(1, 0);
        runs(30, 1'b1, 3, 3, bad, seen);
        check(bad == 0, "R5 no truncated pulse on stop", bad, 0);
        measure(12, 1'b1, act, edges);
        check(act == 0, "R5 output parked at off level", act, 0);

        // R7: off level follows while stopped
        wr(2, 0);
        @(negedge clk);
        check(clk_out == 1'b0, "R7 new off level", clk_out, 0);
        wr(2, 1);
        @(negedge clk);
        check(clk_out == 1'b1, "R7 off level back to 1", clk_out, 1);

        // R6: restart gives full-length first active phase
        wr(1, 2);
        runs(30, 1'b1, 3, 3, bad, seen);
        check(bad == 0, "R6 full first pulse after restart", bad, 0);
        check(seen >= 3, "R6 output resumes", seen, 3);

        // R4: compare change mid-run does not shorten a phase, T=9 C=4->2
        wr(3, 0); wr(2, 0); wr(0, 9); wr(1, 4); wr(3, 1);
        idle(13);
        wr(1, 2);
        runs(50, 1'b0, 5, 7, bad, seen);
        check(bad == 0, "R4 buffered compare, runs of 5 or 7", bad, 0);
        measure(40, 1'b0, act, edges);
        check(act == 28, "R4 new compare in effect", act, 28);

        // R10: lower period below current count
        wr(3, 0); wr(0, 9); wr(1, 4); wr(3, 1);
        idle(6);
        wr(0, 3); wr(1, 1);
        idle(30);
        measure(16, 1'b0, act, edges);
        check(edges == 4, "R10 period after lowering top", edges, 4);
        check(act == 8, "R10 duty after lowering top", act, 8);

        // R8: disabling parks output at off level
        wr(2, 1);
        idle(10);
        wr(3, 0);
        @(negedge clk);
        measure(12, 1'b1, act, edges);
        check(act == 0, "R8 disabled output at off level", act, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule